// File: doc/BRIEF.md
# Dual-CPU Doorbell Interrupt Mailbox

This block lets two processors signal each other through a set of shared interrupt flags. Each destination processor owns a small status word. One processor rings a doorbell by writing ones into the other processor's set register. The receiver reads its status word to find out which doorbells are pending. It acknowledges them by writing ones into its clear register. While a processor's status word holds any set bit, its level interrupt output stays high.

The block sits on a zero-wait, 32-bit, APB-style register port that decodes a 4 KB window. An access is performed in the cycle where select and enable are both high. Read data and the error flag are valid during that same cycle. A read-only bank of twelve identification bytes occupies the top of the window. An access that is illegal raises the error flag for that cycle and changes nothing.

Top module: `doorbell_mailbox`

## Requirements
- R1: While reset is high and after it is released, both status words read as zero and both interrupt outputs are low.
- R2: A write to a CPU's set register (CPU0 at 0x004, CPU1 at 0x014) ORs bits [3:0] of the write data into that CPU's status word. Data bits [31:4] are ignored.
- R3: A write to a CPU's clear register (CPU0 at 0x008, CPU1 at 0x018) clears every status bit that is one in bits [3:0] of the write data. Other status bits are kept.
- R4: Each interrupt output is a register of "status word nonzero". After the access edge that changes the status, the output changes one clock cycle later.
- R5: Reading a status register (CPU0 at 0x000, CPU1 at 0x010) returns the status word in bits [3:0], with bits [31:4] zero. Reading a set or clear register returns zero, and neither read flags an error.
- R6: A write to a status register or to an identification register flags an error and leaves both status words unchanged.
- R7: The words at 0xFD0 through 0xFFC, in steps of 4, read as the bytes 0x04, 0x00, 0x00, 0x00, 0x56, 0xB8, 0x0B, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in that order, zero-extended to 32 bits.
- R8: A read or write to an unmapped word offset flags an error. Such a read returns zero, and such a write changes no state. Offsets 0x00C and 0x01C, and everything from 0x020 to 0xFCC, are unmapped.
- R9: Any access with address bits [1:0] nonzero flags an error, returns zero and changes no state.
- R10: A write aimed at one CPU's registers never changes the other CPU's status word or interrupt.
- R11: Outside the access phase (select and enable both high), the error flag and the read data are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte offset within the 4 KB window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid in the access phase |
| pslverr | output | 1 | Error flag for the current access |
| irq_cpu0 | output | 1 | Level interrupt toward CPU0 |
| irq_cpu1 | output | 1 | Level interrupt toward CPU1 |

## Verification
The hardest case to reach from the ports is an illegal write that overlaps live status. Examples are a misaligned write that lands inside a set register, or a write to a status register whose data would otherwise clear or set bits. The test shows that no status bit moves only because both status words already hold nonzero patterns when those writes are issued. Each illegal write is then followed by a status read-back. Interrupt timing is probed on both sides of the one-cycle register delay. This separates a registered output from a combinational one.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int ADDR_W   = 12;
    localparam int DATA_W   = 32;
    localparam int STAT_W   = 4;
    localparam int NUM_CPU  = 2;
    localparam int CPU_W    = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
    localparam int ID_COUNT = 12;
    localparam logic [ADDR_W-1:0] ID_BASE = 12'hFD0;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_STAT,
        RK_SET,
        RK_CLR,
        RK_ID
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e        kind;
        logic [CPU_W-1:0] cpu;
        logic [3:0]       id_idx;
        logic             misaligned;
    } dec_t;

    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        case (idx)
            4'd0:    return 8'h04;
            4'd4:    return 8'h56;
            4'd5:    return 8'hB8;
            4'd6:    return 8'h0B;
            4'd8:    return 8'h0D;
            4'd9:    return 8'hF0;
            4'd10:   return 8'h05;
            4'd11:   return 8'hB1;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output dec_t              dec
);
    logic [ADDR_W-1:0] id_off;
    logic [ADDR_W-5:0] slot;

    assign id_off = addr - ID_BASE;
    assign slot   = addr[ADDR_W-1:4];

    always_comb begin
        dec            = '0;
        dec.kind       = RK_NONE;
        dec.misaligned = |addr[1:0];
        if (!dec.misaligned) begin
            if (addr >= ID_BASE) begin
                dec.kind   = RK_ID;
                dec.id_idx = id_off[5:2];
            end else if (int'(slot) < NUM_CPU) begin
                dec.cpu = addr[4 +: CPU_W];
                case (addr[3:2])
                    2'd0:    dec.kind = RK_STAT;
                    2'd1:    dec.kind = RK_SET;
                    2'd2:    dec.kind = RK_CLR;
                    default: dec.kind = RK_NONE;
                endcase
            end
        end
    end
endmodule

// File: rtl/mbx_status.sv
module mbx_status
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic [STAT_W-1:0] bits,
    output logic [STAT_W-1:0] status,
    output logic              irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else if (set_en) begin
            status <= status | bits;
        end else if (clr_en) begin
            status <= status & ~bits;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |status;
    end

    // R2
    set_keeps_bits_chk: assert property (@(posedge clk) disable iff (rst)
        set_en |=> ((status & $past(status)) == $past(status)) && ((status & $past(bits)) == $past(bits)));
    // R3
    clr_drops_bits_chk: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> ((status & $past(bits)) == '0));
    // R4
    irq_high_chk: assert property (@(posedge clk) disable iff (rst)
        (status != '0) |=> irq);
    // R4
    irq_low_chk: assert property (@(posedge clk) disable iff (rst)
        (status == '0) |=> !irq);
endmodule

// File: rtl/doorbell_mailbox.sv
module doorbell_mailbox
    import mbx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pslverr,
    output logic              irq_cpu0,
    output logic              irq_cpu1
);
    dec_t              dec;
    logic              access;
    logic              bad;
    logic [DATA_W-1:0] rd_word;
    logic [STAT_W-1:0] stat_w [NUM_CPU];
    logic [NUM_CPU-1:0] irq_w;

    assign access = psel & penable;

    mbx_decode u_dec (
        .addr (paddr),
        .dec  (dec)
    );

    assign bad = dec.misaligned || (dec.kind == RK_NONE) ||
                 (pwrite && (dec.kind == RK_STAT || dec.kind == RK_ID));

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic set_en, clr_en;
        assign set_en = access && pwrite && !bad && dec.kind == RK_SET && dec.cpu == CPU_W'(c);
        assign clr_en = access && pwrite && !bad && dec.kind == RK_CLR && dec.cpu == CPU_W'(c);

        mbx_status u_stat (
            .clk    (clk),
            .rst    (rst),
            .set_en (set_en),
            .clr_en (clr_en),
            .bits   (pwdata[STAT_W-1:0]),
            .status (stat_w[c]),
            .irq    (irq_w[c])
        );

        // R9
        misaligned_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (access && |paddr[1:0]) |=> $stable(stat_w[c]));
        // R6
        err_hold_chk: assert property (@(posedge clk) disable iff (rst)
            pslverr |=> $stable(stat_w[c]));
    end

    always_comb begin
        rd_word = '0;
        case (dec.kind)
            RK_STAT: rd_word[STAT_W-1:0] = stat_w[dec.cpu];
            RK_ID:   rd_word[7:0]        = id_byte(dec.id_idx);
            default: rd_word = '0;
        endcase
    end

    assign pslverr  = access && bad;
    assign prdata   = (access && !bad && !pwrite) ? rd_word : '0;
    assign irq_cpu0 = irq_w[0];
    assign irq_cpu1 = irq_w[1];

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !access |-> (!pslverr && prdata == '0));
    // R5
    rdata_width_chk: assert property (@(posedge clk) disable iff (rst)
        (access && !pwrite && paddr[11:4] == 8'h00) |-> prdata[DATA_W-1:STAT_W] == '0);
    // R1
    reset_clean_chk: assert property (@(posedge clk)
        rst |=> (stat_w[0] == '0 && stat_w[1] == '0));
endmodule

// File: tb/test_doorbell_mailbox.sv
module test_doorbell_mailbox;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pslverr, irq_cpu0, irq_cpu1;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    doorbell_mailbox i_doorbell_mailbox (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pslverr(pslverr),
        .irq_cpu0(irq_cpu0), .irq_cpu1(irq_cpu1)
    );

    // {write, addr, wdata, expected rdata, expected err}
    localparam int NV = 23;
    localparam logic [77:0] VEC [NV] = '{
        {1'b1, 12'h004, 32'h0000_00F5, 32'h0, 1'b0}, // R2 set cpu0, upper bits dropped
        {1'b0, 12'h000, 32'h0, 32'h5, 1'b0},         // R5
        {1'b1, 12'h008, 32'h0000_0001, 32'h0, 1'b0}, // R3
        {1'b0, 12'h000, 32'h0, 32'h4, 1'b0},         // R3
        {1'b0, 12'h004, 32'h0, 32'h0, 1'b0},         // R5 set reads zero
        {1'b1, 12'h014, 32'hFFFF_FFFA, 32'h0, 1'b0}, // R2 cpu1
        {1'b0, 12'h010, 32'h0, 32'hA, 1'b0},         // R2
        {1'b0, 12'h000, 32'h0, 32'h4, 1'b0},         // R10
        {1'b1, 12'h000, 32'h0000_000F, 32'h0, 1'b1}, // R6
        {1'b0, 12'h000, 32'h0, 32'h4, 1'b0},         // R6
        {1'b0, 12'hFD0, 32'h0, 32'h04, 1'b0},        // R7
        {1'b0, 12'hFE0, 32'h0, 32'h56, 1'b0},        // R7
        {1'b0, 12'hFE4, 32'h0, 32'hB8, 1'b0},        // R7
        {1'b0, 12'hFFC, 32'h0, 32'hB1, 1'b0},        // R7
        {1'b0, 12'h020, 32'h0, 32'h0, 1'b1},         // R8
        {1'b1, 12'h020, 32'h0000_000F, 32'h0, 1'b1}, // R8
        {1'b0, 12'h001, 32'h0, 32'h0, 1'b1},         // R9
        {1'b1, 12'h006, 32'h0000_0003, 32'h0, 1'b1}, // R9
        {1'b0, 12'h000, 32'h0, 32'h4, 1'b0},         // R9 no change
        {1'b1, 12'hFD0, 32'h0000_000F, 32'h0, 1'b1}, // R6
        {1'b0, 12'h00C, 32'h0, 32'h0, 1'b1},         // R8
        {1'b1, 12'h018, 32'h0000_00FF, 32'h0, 1'b0}, // R3 cpu1
        {1'b0, 12'h010, 32'h0, 32'h0, 1'b0}          // R3
    };

    localparam logic [7:0] EXP_ID [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h56, 8'hB8,
                                            8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drives on falling edges, samples in access phase; returns after the access edge
    task automatic bus(input logic wr, input logic [11:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic err);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        #1;
        rd = prdata; err = pslverr;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic        er;
        repeat (3) @(negedge clk);
        check("R1 irq0 in reset", {31'b0, irq_cpu0}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 irq1 after reset", {31'b0, irq_cpu1}, 32'h0);
        check("R11 idle err", {31'b0, pslverr}, 32'h0);
        check("R11 idle rdata", prdata, 32'h0);
        bus(1'b0, 12'h000, 32'h0, rd, er);
        check("R1 stat0 after reset", rd, 32'h0);

        for (int i = 0; i < NV; i++) begin
            bus(VEC[i][77], VEC[i][76:65], VEC[i][64:33], rd, er);
            if (!VEC[i][77]) check($sformatf("R5/R7/R8 read vec %0d", i), rd, VEC[i][32:1]);
            check($sformatf("R6/R8/R9 err vec %0d", i), {31'b0, er}, {31'b0, VEC[i][0]});
        end

        for (int k = 0; k < 12; k++) begin
            bus(1'b0, 12'hFD0 + 12'(k * 4), 32'h0, rd, er);
            check($sformatf("R7 id %0d", k), rd, {24'b0, EXP_ID[k]});
        end

        // R4 timing: status is 4 on cpu0, 0 on cpu1 here; irq0 high, irq1 low
        check("R4 irq0 steady", {31'b0, irq_cpu0}, 32'h1);
        check("R10 irq1 idle", {31'b0, irq_cpu1}, 32'h0);
        bus(1'b1, 12'h014, 32'h2, rd, er);
        // bus returned at the falling edge after the access edge: output still old
        check("R4 irq1 not yet", {31'b0, irq_cpu1}, 32'h0);
        @(negedge clk);
        check("R4 irq1 one cycle later", {31'b0, irq_cpu1}, 32'h1);
        bus(1'b1, 12'h008, 32'h4, rd, er);
        check("R4 irq0 still high", {31'b0, irq_cpu0}, 32'h1);
        @(negedge clk);
        check("R4 irq0 drops", {31'b0, irq_cpu0}, 32'h0);
        check("R10 irq1 unaffected", {31'b0, irq_cpu1}, 32'h1);

        // R9 misaligned write inside a clear register on live status
        bus(1'b1, 12'h01A, 32'hF, rd, er);
        check("R9 err", {31'b0, er}, 32'h1);
        bus(1'b0, 12'h010, 32'h0, rd, er);
        check("R9 stat1 held", rd, 32'h2);
        // R5 clear register reads zero without error
        bus(1'b0, 12'h018, 32'h0, rd, er);
        check("R5 clr reads zero", rd, 32'h0);
        check("R5 clr read no err", {31'b0, er}, 32'h0);

        // R1 reset mid-operation
        bus(1'b1, 12'h004, 32'h9, rd, er);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 irq1 cleared", {31'b0, irq_cpu1}, 32'h0);
        check("R1 irq0 cleared", {31'b0, irq_cpu0}, 32'h0);
        rst = 1'b0;
        bus(1'b0, 12'h000, 32'h0, rd, er);
        check("R1 stat0 cleared", rd, 32'h0);
        bus(1'b0, 12'h010, 32'h0, rd, er);
        check("R1 stat1 cleared", rd, 32'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule